// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the coherence directory that sits at the home node of a distributed shared-memory system. For every memory block the node owns, it keeps a state and a presence vector with one bit per processor. Requests reach it from caches as a triple: requesting processor, block address and request kind. For each request it sends out a short sequence of message descriptors: invalidates to sharers, fetch orders to an owner, a data reply to the requester, or a rejection. It then updates the directory entry.

The address is split into two fields. The upper field names the home node and the lower field selects a block within that node's memory. A request whose upper field is not this node's number is refused. The controller serves one request at a time. It shows one message per cycle and holds its ready output low until the whole sequence for the current request has been shown. In the Shared state the presence vector lists every clean copy. In the Exclusive state it holds exactly one bit, which names the owner whose copy is dirty.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty vector, `msg_valid` is 0 and `req_ready` is 1.
- R2: A read, write or write-back request (kinds 0, 1, 2) whose address bits above the offset field differ from `HOME_NODE` produces one NACK (code 5) to the requester and leaves the directory unchanged.
- R3: A read (kind 0) of an Uncached or Shared block produces one DATA (code 1) to the requester. The block becomes Shared and the requester's bit is added to the vector.
- R4: A read of an Exclusive block by a processor other than the owner produces a FETCH (code 3) to the owner and then DATA to the requester. The block becomes Shared, holding both the owner's bit and the requester's bit.
- R5: A write (kind 1) to a Shared block produces one INV (code 2) to each other sharer, in ascending processor number, and then DATA. The requester becomes the sole Exclusive owner.
- R6: A write to an Uncached block produces only DATA. The block becomes Exclusive, owned by the requester.
- R7: A write to an Exclusive block owned by another processor produces a FETCH_INV (code 4) to the old owner and then DATA. The requester becomes the sole owner.
- R8: A read or write by the current owner of an Exclusive block produces only DATA and leaves the entry unchanged.
- R9: A write-back (kind 2) from the owner of an Exclusive block returns it to Uncached with an empty vector and produces no message. A write-back in any other case has no effect, and so does the reserved kind 3.
- R10: A request is accepted only on a cycle with `req_ready` high. Its messages appear one per cycle, starting the cycle after acceptance, with DATA last. `req_ready` stays low until the last message has been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken this cycle |
| req_src | input | PW | Requesting processor number |
| req_addr | input | PW+OFF_W | Block address: node field above block offset |
| req_kind | input | 2 | 0 read, 1 write, 2 write-back, 3 reserved |
| msg_valid | output | 1 | Message descriptor valid |
| msg_kind | output | 3 | 1 DATA, 2 INV, 3 FETCH, 4 FETCH_INV, 5 NACK |
| msg_dest | output | PW | Destination processor |
| msg_addr | output | PW+OFF_W | Block address the message concerns |

## Verification
A request accepted on one rising edge has its first message due in the cycle right after that edge. Each later message is due one cycle after the one before it. `req_ready` rises in the cycle after the last message. The bench keeps a behavioural directory and a queue of expected messages. At each falling edge it compares the head of the queue and the ready flag against the outputs. It then retires that head for the coming edge, so every sample is taken mid-cycle and lines up exactly with the expected cycle.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC     = 4,
  parameter int OFF_W     = 3,
  parameter int HOME_NODE = 2,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int NBLK = 1 << OFF_W,
  localparam int AW   = PW + OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  output logic          msg_valid,
  output logic [2:0]    msg_kind,
  output logic [PW-1:0] msg_dest,
  output logic [AW-1:0] msg_addr
);
  localparam logic [1:0] ST_UN = 2'd0, ST_SH = 2'd1, ST_EX = 2'd2;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_RSV = 2'd3;
  localparam logic [2:0] M_NONE = 3'd0, M_DATA = 3'd1, M_INV = 3'd2,
                         M_FETCH = 3'd3, M_FINV = 3'd4, M_NACK = 3'd5;

  logic [1:0]       dstate [NBLK];
  logic [NPROC-1:0] dvec   [NBLK];

  logic             p_nack, p_fetch, p_finv, p_data;
  logic [PW-1:0]    p_fdest, p_req;
  logic [NPROC-1:0] p_inv;
  logic [AW-1:0]    p_addr;

  function automatic logic [PW-1:0] low_idx(input logic [NPROC-1:0] v);
    low_idx = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (v[i]) low_idx = i[PW-1:0];
  endfunction

  logic [OFF_W-1:0] off;
  logic             home, busy, acc, own;
  logic [1:0]       cur_st;
  logic [NPROC-1:0] cur_vec, rbit;

  assign off     = req_addr[OFF_W-1:0];
  assign home    = req_addr[AW-1:OFF_W] == HOME_NODE[PW-1:0];
  assign cur_st  = dstate[off];
  assign cur_vec = dvec[off];
  assign rbit    = {{(NPROC-1){1'b0}}, 1'b1} << req_src;
  assign own     = cur_vec == rbit;
  assign busy    = p_nack | p_fetch | (|p_inv) | p_data;
  assign req_ready = ~busy;
  assign acc     = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        dstate[b] <= ST_UN;
        dvec[b]   <= '0;
      end
      p_nack <= 1'b0; p_fetch <= 1'b0; p_finv <= 1'b0; p_data <= 1'b0;
      p_fdest <= '0; p_req <= '0; p_inv <= '0; p_addr <= '0;
    end else if (acc) begin
      p_req  <= req_src;
      p_addr <= req_addr;
      if (req_kind != K_RSV) begin
        if (!home) p_nack <= 1'b1;
        else begin
          case (req_kind)
            K_RD: begin
              p_data <= 1'b1;
              if (cur_st == ST_EX && !own) begin
                p_fetch <= 1'b1;
                p_finv  <= 1'b0;
                p_fdest <= low_idx(cur_vec);
                dstate[off] <= ST_SH;
                dvec[off]   <= cur_vec | rbit;
              end else if (cur_st != ST_EX) begin
                dstate[off] <= ST_SH;
                dvec[off]   <= cur_vec | rbit;
              end
            end
            K_WR: begin
              p_data <= 1'b1;
              if (cur_st == ST_EX && !own) begin
                p_fetch <= 1'b1;
                p_finv  <= 1'b1;
                p_fdest <= low_idx(cur_vec);
                dvec[off] <= rbit;
              end else if (cur_st != ST_EX) begin
                p_inv <= cur_vec & ~rbit;
                dstate[off] <= ST_EX;
                dvec[off]   <= rbit;
              end
            end
            K_WB: begin
              if (cur_st == ST_EX && own) begin
                dstate[off] <= ST_UN;
                dvec[off]   <= '0;
              end
            end
            default: ;
          endcase
        end
      end
    end else if (busy) begin
      if (p_nack)       p_nack  <= 1'b0;
      else if (p_fetch) p_fetch <= 1'b0;
      else if (|p_inv)  p_inv   <= p_inv & (p_inv - 1'b1);
      else              p_data  <= 1'b0;
    end
  end

  always_comb begin
    msg_kind = M_NONE;
    msg_dest = p_req;
    if (p_nack) msg_kind = M_NACK;
    else if (p_fetch) begin
      msg_kind = p_finv ? M_FINV : M_FETCH;
      msg_dest = p_fdest;
    end else if (|p_inv) begin
      msg_kind = M_INV;
      msg_dest = low_idx(p_inv);
    end else if (p_data) msg_kind = M_DATA;
  end

  assign msg_valid = busy;
  assign msg_addr  = p_addr;

  AST_DATA_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_DATA |=> !msg_valid); // R10
  AST_ACCEPT_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_kind == K_RD || req_kind == K_WR) |=> msg_valid); // R10
  AST_INV_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_INV |-> msg_dest != p_req); // R5
  AST_WB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == K_WB && home |=> !msg_valid); // R9

  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    AST_EXCL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      dstate[g] == ST_EX |-> $countones(dvec[g]) == 1); // R7
    AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      dstate[g] == ST_UN |-> dvec[g] == '0); // R9
    AST_SHR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      dstate[g] == ST_SH |-> dvec[g] != '0); // R3
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      dstate[g] != 2'd3); // R1
  end
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int NPROC = 4, OFF_W = 3, HOME = 2, PW = 2, AW = PW + OFF_W;
  localparam int NBLK = 1 << OFF_W;
  localparam int M_DATA = 1, M_INV = 2, M_FETCH = 3, M_FINV = 4, M_NACK = 5;
  localparam int UN = 0, SH = 1, EX = 2;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [PW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic req_ready, msg_valid;
  logic [2:0] msg_kind;
  logic [PW-1:0] msg_dest;
  logic [AW-1:0] msg_addr;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NPROC(NPROC), .OFF_W(OFF_W), .HOME_NODE(HOME)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_addr(req_addr), .req_kind(req_kind),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest), .msg_addr(msg_addr));

  int checks = 0, fails = 0;
  int st [NBLK];
  int vec [NBLK];
  int qk[$], qd[$], qa[$];
  string qt[$];

  task automatic push(int k, int d, int a, string t);
    qk.push_back(k); qd.push_back(d); qa.push_back(a); qt.push_back(t);
  endtask

  function automatic int owner_of(int v);
    for (int i = 0; i < NPROC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic model(int s, int a, int k);
    int o = a % NBLK;
    int b = 1 << s;
    if (k == 3) return;                                   // R9 reserved
    if ((a >> OFF_W) != HOME) begin push(M_NACK, s, a, "R2"); return; end
    case (k)
      0: if (st[o] == EX && vec[o] != b) begin
           push(M_FETCH, owner_of(vec[o]), a, "R4"); push(M_DATA, s, a, "R4");
           vec[o] |= b; st[o] = SH;
         end else if (st[o] == EX) push(M_DATA, s, a, "R8");
         else begin push(M_DATA, s, a, "R3"); vec[o] |= b; st[o] = SH; end
      1: if (st[o] == EX && vec[o] != b) begin
           push(M_FINV, owner_of(vec[o]), a, "R7"); push(M_DATA, s, a, "R7"); vec[o] = b;
         end else if (st[o] == EX) push(M_DATA, s, a, "R8");
         else if (st[o] == SH) begin
           for (int p = 0; p < NPROC; p++) if (vec[o][p] && p != s) push(M_INV, p, a, "R5");
           push(M_DATA, s, a, "R5"); vec[o] = b; st[o] = EX;
         end else begin push(M_DATA, s, a, "R6"); vec[o] = b; st[o] = EX; end
      default: if (st[o] == EX && vec[o] == b) begin st[o] = UN; vec[o] = 0; end
    endcase
  endtask

  task automatic step(bit v, int s, int a, int k, output bit took);
    @(negedge clk);
    checks++;
    if (req_ready !== (qk.size() == 0)) begin
      fails++; $display("FAIL R10 req_ready actual %0b expected %0b", req_ready, qk.size() == 0);
    end
    checks++;
    if (qk.size() == 0) begin
      if (msg_valid !== 1'b0) begin
        fails++; $display("FAIL R9 msg_valid actual %0b expected 0 (kind %0d)", msg_valid, msg_kind);
      end
    end else if (msg_valid !== 1'b1 || msg_kind != qk[0] || msg_dest != qd[0] || msg_addr != qa[0]) begin
      fails++;
      $display("FAIL %s msg actual v%0b k%0d d%0d a%0d expected v1 k%0d d%0d a%0d",
               qt[0], msg_valid, msg_kind, msg_dest, msg_addr, qk[0], qd[0], qa[0]);
    end
    took = v && qk.size() == 0;
    if (qk.size() != 0) begin
      void'(qk.pop_front()); void'(qd.pop_front()); void'(qa.pop_front()); void'(qt.pop_front());
    end
    if (took) model(s, a, k);
    req_valid = v; req_src = PW'(s); req_addr = AW'(a); req_kind = 2'(k);
  endtask

  task automatic issue(int s, int o, int k, int node = HOME);
    bit took;
    do step(1'b1, s, (node << OFF_W) | o, k, took); while (!took);
  endtask

  task automatic idle(int n);
    bit took;
    repeat (n) step(1'b0, 0, 0, 0, took);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NBLK; b++) begin st[b] = UN; vec[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (msg_valid !== 1'b0 || req_ready !== 1'b1) begin   // R1 in reset
      fails++; $display("FAIL R1 reset v%0b r%0b expected v0 r1", msg_valid, req_ready);
    end
    rst_n = 1;
    idle(2);                                              // R1 idle after reset
    issue(0, 1, 0); issue(1, 1, 0); issue(3, 1, 0);       // R3 sharers 0,1,3
    issue(1, 1, 1);                                       // R5 INV 0, INV 3, DATA
    issue(2, 1, 0);                                       // R4 FETCH to 1
    issue(0, 2, 1); issue(3, 2, 1);                       // R6 then R7
    issue(3, 2, 0); issue(3, 2, 1);                       // R8 owner access
    issue(1, 2, 2); issue(0, 2, 0);                       // R9 ignored write-back, R4 fetch from 3
    issue(2, 4, 1); issue(2, 4, 2); issue(1, 4, 0);       // R9 owner write-back, then plain read
    issue(0, 4, 3); issue(0, 4, 1);                       // R9 reserved kind, R5 INV 1
    issue(0, 1, 0, 1); issue(3, 1, 1, 3);                 // R2 foreign homes
    issue(3, 1, 1);                                       // R5 after R2: state untouched
    idle(3);
    for (int i = 0; i < 400; i++) begin
      int node = ($urandom_range(0, 7) == 0) ? 1 : HOME;
      issue($urandom_range(0, NPROC - 1), $urandom_range(0, NBLK - 1), $urandom_range(0, 3), node);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule